// File: doc/BRIEF.md
# Nibble Rotate-Through-Memory Unit

This unit carries out the two decimal-digit rotate instructions of an 8-bit processor core. Each instruction moves 4-bit digits around three places in one operation: the low nibble of the accumulator and the two halves of one memory byte. The core gives a start pulse together with a direction select, the current accumulator, the current flag byte and the memory address. The unit then reads the byte at that address, writes the rotated byte back to the same address, and returns the new accumulator and flag byte with a one-cycle done pulse. The done pulse appears after the instruction's full cycle budget.

Memory is reached through a single request channel that uses valid/ready. A request is offered by holding `mem_req_valid_o` high, and it is accepted on the rising edge where `mem_req_ready_i` is also high. While the request waits, its write select, address and write data do not change. The memory applies back-pressure by holding ready low for as long as it needs. A read returns its byte on the response channel: `mem_rsp_valid_i` is high for one cycle with `mem_rsp_data_i`. This can happen in the same cycle that follows acceptance, or any number of cycles later. The unit always takes the response, so the response channel has no ready signal.

The outputs `acc_o` and `flags_o` are valid while `done_o` is high. They keep their values until the next operation completes. Instruction fetch, the forming of the address and the memory itself belong to the surrounding core.

Top module: `nibble_rot_unit`

## Requirements
- R1: With `dir_left_i`=0 (rotate right), the byte written to memory carries the old accumulator low nibble in bits 7:4 and the old memory high nibble in bits 3:0.
- R2: With `dir_left_i`=0, `acc_o` keeps the old accumulator high nibble in bits 7:4 and takes the old memory low nibble in bits 3:0.
- R3: With `dir_left_i`=1 (rotate left), the byte written to memory carries the old memory low nibble in bits 7:4 and the old accumulator low nibble in bits 3:0.
- R4: With `dir_left_i`=1, `acc_o` keeps the old accumulator high nibble in bits 7:4 and takes the old memory high nibble in bits 3:0.
- R5: `flags_o` has the bit layout S=7, Z=6, copy of result bit 5 at bit 5, H=4, copy of result bit 3 at bit 3, P/V=2, N=1, C=0. S is bit 7 of the new accumulator. Z is set when the new accumulator is zero. P/V is set when the new accumulator has an even number of one bits. H and N are cleared. C equals bit 0 of `flags_i` at start. No other bit of `flags_i` has any effect.
- R6: Each operation issues exactly one read and then exactly one write. The write is offered only after the read byte has arrived, and it goes to the address sampled at start.
- R7: `done_o` is high for exactly one cycle. It rises on edge max(S+17, W+1), where S is the edge that samples the start and W is the edge that accepts the write. With a memory that never stalls, this is the 18th rising edge counting S as the first.
- R8: A start pulse, or a change on `acc_i`, `flags_i`, `dir_left_i` or `addr_i`, while an operation is in progress has no effect on that operation or its results. A start is accepted only when idle or in the cycle where `done_o` is high.
- R9: After reset, `done_o` and `mem_req_valid_o` are low and `acc_o` and `flags_o` are zero.
- R10: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid and its write select, address and write data are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (one-cycle pulse) |
| dir_left_i | input | 1 | 1 = rotate left, 0 = rotate right |
| acc_i | input | 8 | Accumulator value at start |
| flags_i | input | 8 | Flag byte at start; only bit 0 is used |
| addr_i | input | ADDR_W (16) | Address of the memory operand |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | 8 | New accumulator |
| flags_o | output | 8 | New flag byte |
| mem_req_valid_o | output | 1 | Memory request offered |
| mem_req_ready_i | input | 1 | Memory accepts the request on this edge |
| mem_req_write_o | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr_o | output | ADDR_W (16) | Request address |
| mem_req_wdata_o | output | 8 | Write data |
| mem_rsp_valid_i | input | 1 | Read data present |
| mem_rsp_data_i | input | 8 | Read data |

## Verification
The assertions assume that the memory side obeys the channel rules. A response arrives only for a read that was accepted, at most one response comes per read, and reset is held for a few cycles before the first start. The bench's memory model keeps to these rules. It answers only the read it accepted, with a latency drawn at random from zero to a mode-dependent limit, and it draws the ready signal at random within each stall mode. Start pulses are sent to a busy unit only after the operation has begun. This exercises the ignore rule without making assumptions about back-to-back timing.

// File: rtl/nrot_pkg.sv
package nrot_pkg;

  // Flag byte bit positions
  localparam int FLAG_C  = 0;
  localparam int FLAG_N  = 1;
  localparam int FLAG_PV = 2;
  localparam int FLAG_X3 = 3;
  localparam int FLAG_H  = 4;
  localparam int FLAG_X5 = 5;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_S  = 7;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_HOLD    = 3'd4,
    ST_DONE    = 3'd5
  } nrot_state_e;

  typedef enum logic {
    DIR_RIGHT = 1'b0,
    DIR_LEFT  = 1'b1
  } nrot_dir_e;

endpackage

// File: rtl/nrot_seq.sv
module nrot_seq
  import nrot_pkg::*;
#(
  parameter int CYCLES = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  output logic load_o,
  output logic take_o,
  output logic req_valid_o,
  output logic req_write_o,
  output logic commit_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(CYCLES) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES - 1);

  nrot_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic idle_like;
  logic busy;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign busy      = !idle_like;
  assign load_o    = start_i && idle_like;
  assign take_o    = (state_q == ST_RD_WAIT) && rsp_valid_i;
  assign commit_o  = (state_q == ST_HOLD) && (cnt_q >= CNT_LAST);
  assign done_o    = (state_q == ST_DONE);

  assign req_valid_o = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign req_write_o = (state_q == ST_WR_REQ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: state_d = load_o ? ST_RD_REQ : ST_IDLE;
      ST_RD_REQ:        if (req_ready_i) state_d = ST_RD_WAIT;
      ST_RD_WAIT:       if (rsp_valid_i) state_d = ST_WR_REQ;
      ST_WR_REQ:        if (req_ready_i) state_d = ST_HOLD;
      ST_HOLD:          if (commit_o)    state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        cnt_q <= CNT_W'(1);
      end else if (busy && (cnt_q != CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Done lasts one cycle unless a new start turns it straight into a new run.
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // A stalled request keeps being offered with the same kind.
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_write_o)));

  // A start while busy leaves the run in progress untouched.
  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy) |-> !load_o);

endmodule

// File: rtl/nrot_shuffle.sv
module nrot_shuffle
  import nrot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              take_i,
  input  logic              commit_i,
  input  logic              dir_left_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wbyte_o,
  output logic [DATA_W-1:0] new_acc_o,
  output logic              have_byte_o
);

  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] mem_q;
  logic [ADDR_W-1:0] addr_q;
  nrot_dir_e         dir_q;
  logic              have_q;

  logic [NIB_W-1:0] acc_hi, acc_lo, mem_hi, mem_lo;

  assign acc_hi = acc_q[DATA_W-1:NIB_W];
  assign acc_lo = acc_q[NIB_W-1:0];
  assign mem_hi = mem_q[DATA_W-1:NIB_W];
  assign mem_lo = mem_q[NIB_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mem_q  <= '0;
      addr_q <= '0;
      dir_q  <= DIR_RIGHT;
      have_q <= 1'b0;
    end else begin
      if (load_i) begin
        acc_q  <= acc_i;
        addr_q <= addr_i;
        dir_q  <= nrot_dir_e'(dir_left_i);
        have_q <= 1'b0;
      end else if (take_i) begin
        mem_q  <= rdata_i;
        have_q <= 1'b1;
      end
    end
  end

  always_comb begin
    if (dir_q == DIR_LEFT) begin
      wbyte_o   = {mem_lo, acc_lo};
      new_acc_o = {acc_hi, mem_hi};
    end else begin
      wbyte_o   = {acc_lo, mem_hi};
      new_acc_o = {acc_hi, mem_lo};
    end
  end

  assign addr_o      = addr_q;
  assign have_byte_o = have_q;

  // The run cannot finish before its memory byte was captured.
  assert_commit_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> have_q);

  // Operand address does not move between load and commit.
  assert_addr_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && !load_i) |=> $stable(addr_q));

endmodule

// File: rtl/nrot_flags.sv
module nrot_flags
  import nrot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              commit_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] res_i,
  output logic [7:0]        flags_o
);

  logic       carry_q;
  logic [7:0] flags_q;
  logic [7:0] flags_d;

  always_comb begin
    flags_d          = '0;
    flags_d[FLAG_S]  = res_i[DATA_W-1];
    flags_d[FLAG_Z]  = (res_i == '0);
    flags_d[FLAG_X5] = res_i[5];
    flags_d[FLAG_H]  = 1'b0;
    flags_d[FLAG_X3] = res_i[3];
    flags_d[FLAG_PV] = ~(^res_i);
    flags_d[FLAG_N]  = 1'b0;
    flags_d[FLAG_C]  = carry_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      flags_q <= '0;
    end else begin
      if (load_i)   carry_q <= carry_i;
      if (commit_i) flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  // The carry that was captured at start is the one that appears at commit.
  assert_carry_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (flags_q[FLAG_C] == carry_q));

endmodule

// File: rtl/nibble_rot_unit.sv
module nibble_rot_unit
  import nrot_pkg::*;
#(
  parameter int CYCLES = 18,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_left_i,
  input  logic [7:0]        acc_i,
  input  logic [7:0]        flags_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic [7:0]        acc_o,
  output logic [7:0]        flags_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [7:0]        mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [7:0]        mem_rsp_data_i
);

  localparam int DATA_W = 8;

  logic              load, take, commit, have_byte;
  logic [DATA_W-1:0] new_acc;
  logic [DATA_W-1:0] acc_q;
  logic              unused_flag_bits;

  assign unused_flag_bits = ^flags_i[7:1];

  nrot_seq #(.CYCLES(CYCLES)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .load_o      (load),
    .take_o      (take),
    .req_valid_o (mem_req_valid_o),
    .req_write_o (mem_req_write_o),
    .commit_o    (commit),
    .done_o      (done_o)
  );

  nrot_shuffle #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) shuffle_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .take_i      (take),
    .commit_i    (commit),
    .dir_left_i  (dir_left_i),
    .acc_i       (acc_i),
    .addr_i      (addr_i),
    .rdata_i     (mem_rsp_data_i),
    .addr_o      (mem_req_addr_o),
    .wbyte_o     (mem_req_wdata_o),
    .new_acc_o   (new_acc),
    .have_byte_o (have_byte)
  );

  nrot_flags #(.DATA_W(DATA_W)) flags_i_u (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .commit_i (commit),
    .carry_i  (flags_i[FLAG_C]),
    .res_i    (new_acc),
    .flags_o  (flags_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (commit) acc_q <= new_acc;
  end

  assign acc_o = acc_q;

  // A write is offered only once the read byte is held.
  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_write_o) |-> have_byte);

  // A stalled request keeps address and data.
  assert_req_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      ($stable(mem_req_addr_o) && $stable(mem_req_wdata_o)));

  // Flag byte agrees with the accumulator register it accompanies.
  assert_flags_track_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((flags_o[FLAG_Z] == (acc_o == 8'h00)) &&
                (flags_o[FLAG_PV] == ~(^acc_o)) &&
                (flags_o[FLAG_S] == acc_o[7]) &&
                !flags_o[FLAG_H] && !flags_o[FLAG_N]));

endmodule

// File: tb/nibble_rot_unit_tb.sv
module nibble_rot_unit_tb_top;

  localparam int CYC_BUDGET = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        dir_left_i = 1'b0;
  logic [7:0]  acc_i = '0;
  logic [7:0]  flags_i = '0;
  logic [15:0] addr_i = '0;
  logic        done_o;
  logic [7:0]  acc_o, flags_o;
  logic        mem_req_valid_o, mem_req_write_o;
  logic        mem_req_ready_i = 1'b0;
  logic [15:0] mem_req_addr_o;
  logic [7:0]  mem_req_wdata_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [7:0]  mem_rsp_data_i = '0;

  always #5 clk = ~clk;

  nibble_rot_unit #(.CYCLES(CYC_BUDGET), .ADDR_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_left_i(dir_left_i),
    .acc_i(acc_i), .flags_i(flags_i), .addr_i(addr_i),
    .done_o(done_o), .acc_o(acc_o), .flags_o(flags_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_write_o(mem_req_write_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int stall_mode = 0;

  logic [7:0] mem [256];
  logic [7:0] pend_data = '0;
  int         pend_cnt = 0;

  int rd_n = 0, wr_n = 0, rd_edge = 0, wr_edge = 0;
  logic [15:0] rd_addr = '0, wr_addr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural memory with random back-pressure and read latency
  always @(posedge clk) begin
    int lat;
    mem_rsp_valid_i <= 1'b0;
    if (pend_cnt != 0) begin
      if (pend_cnt == 1) begin
        mem_rsp_valid_i <= 1'b1;
        mem_rsp_data_i  <= pend_data;
      end
      pend_cnt <= pend_cnt - 1;
    end
    if (rst_n && mem_req_valid_o && mem_req_ready_i) begin
      if (mem_req_write_o) begin
        mem[mem_req_addr_o[7:0]] <= mem_req_wdata_o;
      end else begin
        lat = (stall_mode == 0) ? 0 : (stall_mode == 1) ? int'($urandom % 4) : int'($urandom % 9);
        if (lat == 0) begin
          mem_rsp_valid_i <= 1'b1;
          mem_rsp_data_i  <= mem[mem_req_addr_o[7:0]];
        end else begin
          pend_data <= mem[mem_req_addr_o[7:0]];
          pend_cnt  <= lat;
        end
      end
    end
    case (stall_mode)
      0:       mem_req_ready_i <= 1'b1;
      1:       mem_req_ready_i <= ($urandom % 4) != 0;
      default: mem_req_ready_i <= ($urandom % 8) == 0;
    endcase
  end

  // Handshake monitor
  always @(negedge clk) begin
    if (rst_n && mem_req_valid_o && mem_req_ready_i) begin
      if (mem_req_write_o) begin
        wr_n++; wr_edge = cyc + 1; wr_addr = mem_req_addr_o;
      end else begin
        rd_n++; rd_edge = cyc + 1; rd_addr = mem_req_addr_o;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: run did not end, actual cycle %0d expected below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mem(input bit left, input logic [7:0] a, input logic [7:0] m);
    return left ? {m[3:0], a[3:0]} : {a[3:0], m[7:4]};
  endfunction

  function automatic logic [7:0] exp_acc(input bit left, input logic [7:0] a, input logic [7:0] m);
    return left ? {a[7:4], m[7:4]} : {a[7:4], m[3:0]};
  endfunction

  function automatic logic [7:0] exp_flags(input logic [7:0] r, input bit c);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += r[i];
    return {r[7], (r == 8'h00), r[5], 1'b0, r[3], (ones % 2 == 0), 1'b0, c};
  endfunction

  task automatic run_op(input bit left, input logic [7:0] a, input logic [7:0] f,
                        input logic [15:0] ad, input logic [7:0] m,
                        input int smode, input bit poke);
    int s, guard, exp_done;
    logic [7:0] em, ea, ef;
    string rm, ra;
    rm = left ? "R3" : "R1";
    ra = left ? "R4" : "R2";
    @(negedge clk);
    mem[ad[7:0]] = m;
    rd_n = 0; wr_n = 0;
    stall_mode = smode;
    dir_left_i = left; acc_i = a; flags_i = f; addr_i = ad; start_i = 1'b1;
    s = cyc + 1;
    @(negedge clk);
    start_i = 1'b0;
    acc_i = 8'($urandom); flags_i = 8'($urandom);
    dir_left_i = 1'($urandom); addr_i = 16'($urandom);
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; acc_i = ~a; dir_left_i = ~left;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (!done_o) begin
      chk(1'b0, "R7", "done never rose", 0, 1);
      return;
    end
    em = exp_mem(left, a, m);
    ea = exp_acc(left, a, m);
    ef = exp_flags(ea, f[0]);
    exp_done = (s + CYC_BUDGET - 1 > wr_edge + 1) ? s + CYC_BUDGET - 1 : wr_edge + 1;
    chk(mem[ad[7:0]] == em, rm, "memory byte", int'(mem[ad[7:0]]), int'(em));
    chk(acc_o == ea, ra, "accumulator", int'(acc_o), int'(ea));
    chk(flags_o == ef, "R5", "flags", int'(flags_o), int'(ef));
    chk(rd_n == 1 && wr_n == 1, "R6", "read+write count", rd_n * 16 + wr_n, 17);
    chk(rd_addr == ad && wr_addr == ad, "R6", "addresses", int'(wr_addr), int'(ad));
    chk(rd_edge < wr_edge, "R6", "read before write", rd_edge, wr_edge);
    chk(cyc == exp_done, "R7", "done edge", cyc, exp_done);
    if (poke) chk(rd_n == 1, "R8", "busy start ignored (reads)", rd_n, 1);
    @(negedge clk);
    chk(!done_o, "R7", "done single pulse", int'(done_o), 0);
    chk(acc_o == ea && flags_o == ef, "R8", "results held", int'(acc_o), int'(ea));
  endtask

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd24681);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    chk(!done_o, "R9", "done after reset", int'(done_o), 0);
    chk(!mem_req_valid_o, "R9", "request after reset", int'(mem_req_valid_o), 0);
    chk(acc_o == 8'h00, "R9", "acc after reset", int'(acc_o), 0);
    chk(flags_o == 8'h00, "R9", "flags after reset", int'(flags_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed corners
    run_op(1'b0, 8'h12, 8'h00, 16'h0040, 8'h34, 0, 1'b0); // R1/R2 basic
    run_op(1'b1, 8'h12, 8'hFE, 16'h0041, 8'h34, 0, 1'b0); // R3/R4, other flags ignored
    run_op(1'b0, 8'h05, 8'h01, 16'h0042, 8'h30, 0, 1'b0); // R5 zero result, carry kept
    run_op(1'b1, 8'hA0, 8'hFF, 16'h1280, 8'h8F, 0, 1'b0); // R5 sign, bits 5/3
    run_op(1'b0, 8'h77, 8'h00, 16'h0010, 8'hC9, 2, 1'b0); // R7 heavy back-pressure
    run_op(1'b1, 8'h3C, 8'h01, 16'h0011, 8'h5A, 1, 1'b1); // R8 start while busy
    run_op(1'b0, 8'hFF, 8'h00, 16'h00FF, 8'hFF, 0, 1'b1); // R8 with no stalls

    // Random mix
    for (int k = 0; k < 40; k++) begin
      run_op(1'($urandom), 8'($urandom), 8'($urandom), 16'($urandom),
             8'($urandom), int'($urandom % 3), ($urandom % 4) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule